// File: doc/BRIEF.md
# Peripheral Window Default Responder

This block watches a request bus aimed at the processor's private peripheral window, the 1 MiB range 0xE0000000 to 0xE00FFFFF. Implemented sub-blocks in that window raise hit lines when they own the current address. The block picks one owner among them. When nobody owns an in-window address, the block answers the access itself. Privileged requests read as zero and have their write data thrown away. Unprivileged requests complete with a bus error.

The block also sorts each answered address into one of three regions: the system control page at 0xE000E000 to 0xE000EFFF, its non-secure alias at 0xE002E000 to 0xE002EFFF, or the rest of the window. It reports that region with the response.

A small state machine holds the response. It has three named states:
- `RSP_IDLE`: no response is pending.
- `RSP_ZERO`: a zero-data answer is pending.
- `RSP_FAULT`: an error answer is pending.

The transitions are:
- `IDLE->ZERO`: taken on a privileged default claim.
- `IDLE->FAULT`: taken on an unprivileged default claim.
- `ZERO/FAULT->IDLE`: taken when the response is consumed and no new claim arrives.
- `ZERO/FAULT->ZERO/FAULT`: taken when the response is consumed in the same cycle that a new claim is accepted.

Top module: `ppb_default_responder`

## Requirements
- R1: After reset `rsp_valid`, `rsp_err` and `hit_conflict` are 0, `rsp_region` is 0, and `req_ready` is 1.
- R2: A request whose address lies outside 0xE0000000..0xE00FFFFF produces no response and no grant, whatever the hit lines show.
- R3: An accepted privileged in-window request with no honoured hit gets `rsp_valid` in the cycle after acceptance, with `rsp_err`=0 and `rsp_rdata`=0. This holds for reads and writes alike, so written data never reappears.
- R4: An accepted unprivileged in-window request with no honoured hit gets `rsp_valid` in the next cycle with `rsp_err`=1 and `rsp_rdata`=0.
- R5: Any honoured hit suppresses the default response. `sub_grant` is one-hot on the lowest-indexed honoured hit, where bit i corresponds to `sub_hit[i]`. It is combinational while `req_valid` is high.
- R6: `hit_conflict` becomes 1 the cycle after an accepted in-window request with two or more honoured hits. It stays 1 until reset.
- R7: `rsp_region` encodes the request's region: 1 for 0xE000E000..0xE000EFFF, 2 for 0xE002E000..0xE002EFFF, and 0 for any other in-window address.
- R8: In the alias region, hits are honoured only when `req_nonsec`=0. A non-secure request to the alias is always answered by default, according to its privilege.
- R9: A response stays valid with stable `rsp_err` and `rsp_region` until `rsp_ready` is 1. `req_ready` is 0 while a response waits unconsumed. When `rsp_ready` is 1, a new request is accepted in the same cycle that the old response is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write data (discarded) |
| req_size | input | 2 | Access size code (not decoded) |
| req_priv | input | 1 | 1 = privileged access |
| req_nonsec | input | 1 | 1 = non-secure access |
| sub_hit | input | N_SUB | Claim lines from implemented sub-blocks |
| sub_grant | output | N_SUB | One-hot selected owner |
| rsp_valid | output | 1 | Default response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | DATA_W | Read data (always zero) |
| rsp_region | output | 2 | Region code of the answered request |
| hit_conflict | output | 1 | Sticky multiple-hit flag |

## Verification
The assertions guard several properties on every cycle:
- `sub_grant` is at most one-hot and is a subset of the hit lines.
- The conflict flag is sticky.
- Read data is zero whenever a response is valid.
- A pending response holds steady under back-pressure.
- A default claim leads to a response one cycle later, with the error bit matching privilege.
- A granted request leaves no default response behind.

Some behaviours can only be shown by the bench's directed scenarios:
- The address boundaries of the window, the control page and the alias.
- Secure versus non-secure handling of alias hits.
- The lowest-index arbitration order.
- Back-to-back acceptance.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    typedef enum logic [1:0] {
        RGN_PPB    = 2'd0,
        RGN_SCS    = 2'd1,
        RGN_SCS_NS = 2'd2
    } ppb_region_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_ZERO  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/ppb_window_decode.sv
module ppb_window_decode
    import ppb_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          N_SUB      = 4,
    parameter logic [31:0] WIN_BASE   = 32'hE000_0000,
    parameter int          WIN_LG2    = 20,
    parameter logic [31:0] SCS_BASE   = 32'hE000_E000,
    parameter logic [31:0] ALIAS_BASE = 32'hE002_E000,
    parameter int          PAGE_LG2   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              nonsec,
    input  logic [N_SUB-1:0]  hits,
    output logic              in_win,
    output ppb_region_e       region,
    output logic [N_SUB-1:0]  eff_hits
);
    localparam int WIN_TAG_W  = ADDR_W - WIN_LG2;
    localparam int PAGE_TAG_W = ADDR_W - PAGE_LG2;

    logic [WIN_TAG_W-1:0]  win_tag;
    logic [PAGE_TAG_W-1:0] page_tag;
    logic                  is_scs;
    logic                  is_alias;

    assign win_tag  = addr[ADDR_W-1:WIN_LG2];
    assign page_tag = addr[ADDR_W-1:PAGE_LG2];
    assign in_win   = (win_tag == WIN_BASE[ADDR_W-1:WIN_LG2]);
    assign is_scs   = (page_tag == SCS_BASE[ADDR_W-1:PAGE_LG2]);
    assign is_alias = (page_tag == ALIAS_BASE[ADDR_W-1:PAGE_LG2]);

    always_comb begin
        if (is_scs)        region = RGN_SCS;
        else if (is_alias) region = RGN_SCS_NS;
        else               region = RGN_PPB;
    end

    // Non-secure accesses through the alias never reach implemented registers.
    always_comb begin
        if (!in_win || (is_alias && nonsec)) eff_hits = '0;
        else                                 eff_hits = hits;
    end
endmodule

// File: rtl/ppb_hit_arbiter.sv
module ppb_hit_arbiter #(
    parameter int N_SUB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SUB-1:0] hits,
    input  logic             sample,
    output logic [N_SUB-1:0] grant,
    output logic             conflict
);
    logic [N_SUB:0] seen;
    logic           multi;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N_SUB; i++) begin : g_pick
        assign grant[i]  = hits[i] & ~seen[i];
        assign seen[i+1] = seen[i] | hits[i];
    end

    assign multi = |(hits & ~grant);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               conflict <= 1'b0;
        else if (sample && multi) conflict <= 1'b1;
    end

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~hits) == '0);
    assert_conflict_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict);
endmodule

// File: rtl/ppb_resp_fsm.sv
module ppb_resp_fsm
    import ppb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        claim,
    input  logic        claim_priv,
    input  ppb_region_e claim_region,
    input  logic        rsp_ready,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [1:0]  rsp_region,
    output logic        can_accept
);
    rsp_state_e  state_q, state_d;
    ppb_region_e region_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RSP_IDLE;
            region_q <= RGN_PPB;
        end else begin
            state_q <= state_d;
            if (claim) region_q <= claim_region;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: begin
                if (claim) state_d = claim_priv ? RSP_ZERO : RSP_FAULT;
            end
            RSP_ZERO, RSP_FAULT: begin
                if (rsp_ready) begin
                    if (claim) state_d = claim_priv ? RSP_ZERO : RSP_FAULT;
                    else       state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_ZERO:  rsp_valid = 1'b1;
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
        rsp_region = region_q;
        can_accept = !rsp_valid || rsp_ready;
    end

    assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_region)));
    assert_no_accept_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !can_accept);
endmodule

// File: rtl/ppb_default_responder.sv
module ppb_default_responder
    import ppb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int N_SUB  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_size,
    input  logic              req_priv,
    input  logic              req_nonsec,
    input  logic [N_SUB-1:0]  sub_hit,
    output logic [N_SUB-1:0]  sub_grant,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_region,
    output logic              hit_conflict
);
    logic              in_win;
    ppb_region_e       region;
    logic [N_SUB-1:0]  eff_hits;
    logic [N_SUB-1:0]  grant_raw;
    logic              accept;
    logic              claim;
    logic              unused_fields;

    // Write data, size and direction do not change a default answer.
    assign unused_fields = ^{req_write, req_wdata, req_size};

    ppb_window_decode #(
        .ADDR_W (ADDR_W),
        .N_SUB  (N_SUB)
    ) i_decode (
        .addr     (req_addr),
        .nonsec   (req_nonsec),
        .hits     (sub_hit),
        .in_win   (in_win),
        .region   (region),
        .eff_hits (eff_hits)
    );

    assign accept = req_valid && req_ready;

    ppb_hit_arbiter #(
        .N_SUB (N_SUB)
    ) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (eff_hits),
        .sample   (accept),
        .grant    (grant_raw),
        .conflict (hit_conflict)
    );

    assign sub_grant = req_valid ? grant_raw : '0;
    assign claim     = accept && in_win && (eff_hits == '0);

    ppb_resp_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .claim        (claim),
        .claim_priv   (req_priv),
        .claim_region (region),
        .rsp_ready    (rsp_ready),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_region   (rsp_region),
        .can_accept   (req_ready)
    );

    assign rsp_rdata = '0;

    assert_claim_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_win && (sub_grant == '0)) |=> rsp_valid);
    assert_unpriv_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_win && (sub_grant == '0) && !req_priv) |=> rsp_err);
    assert_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata == '0));
    assert_granted_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (sub_grant != '0)) |=> !rsp_valid);
endmodule

// File: tb/test_ppb_default_responder.sv
module test_ppb_default_responder;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_size = 2'd2;
    logic        req_priv = 1'b1;
    logic        req_nonsec = 1'b0;
    logic [NS-1:0] sub_hit = '0;
    logic [NS-1:0] sub_grant;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_region;
    logic        hit_conflict;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppb_default_responder #(.ADDR_W(32), .DATA_W(32), .N_SUB(NS)) i_ppb_default_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_size(req_size), .req_priv(req_priv), .req_nonsec(req_nonsec),
        .sub_hit(sub_hit), .sub_grant(sub_grant), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .rsp_region(rsp_region), .hit_conflict(hit_conflict)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access with rsp_ready high; checks grant, response and its retirement.
    task automatic access(input string req, input logic [31:0] addr, input logic wr,
                          input logic priv, input logic ns, input logic [NS-1:0] hits,
                          input logic exp_rsp, input logic exp_err,
                          input logic [1:0] exp_rgn, input logic [NS-1:0] exp_grant);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = 32'hA5A5_5A5A;
        req_priv = priv; req_nonsec = ns; sub_hit = hits;
        #1;
        check(req, "grant", 32'(sub_grant), 32'(exp_grant));
        check(req, "ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; sub_hit = '0;
        check(req, "rsp_valid", 32'(rsp_valid), 32'(exp_rsp));
        if (exp_rsp) begin
            check(req, "rsp_err", 32'(rsp_err), 32'(exp_err));
            check(req, "rsp_rdata", rsp_rdata, 32'd0);
            check(req, "rsp_region", 32'(rsp_region), 32'(exp_rgn));
        end
        @(negedge clk);
        check(req, "rsp retired", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1", "rsp_err", 32'(rsp_err), 32'd0);
        check("R1", "hit_conflict", 32'(hit_conflict), 32'd0);
        check("R1", "rsp_region", 32'(rsp_region), 32'd0);
        check("R1", "req_ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_window();
        access("R2", 32'hDFFF_FFFC, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000);
        access("R2", 32'hE010_0000, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0, 2'd0, 4'b0000);
        access("R2", 32'hE000_0000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        access("R2", 32'hE00F_FFFC, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 2'd0, 4'b0000);
    endtask

    task automatic t_priv_unpriv();
        access("R3", 32'hE000_1000, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        access("R3", 32'hE000_1000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        access("R4", 32'hE004_0000, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 2'd0, 4'b0000);
        access("R4", 32'hE000_E010, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 2'd1, 4'b0000);
    endtask

    task automatic t_hits();
        access("R5", 32'hE000_E100, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 2'd0, 4'b1000);
        check("R6", "no conflict yet", 32'(hit_conflict), 32'd0);
        access("R5", 32'hE000_2000, 1'b0, 1'b1, 1'b0, 4'b0110, 1'b0, 1'b0, 2'd0, 4'b0010);
        check("R6", "conflict set", 32'(hit_conflict), 32'd1);
        access("R6", 32'hE000_3000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        check("R6", "conflict sticky", 32'(hit_conflict), 32'd1);
    endtask

    task automatic t_regions();
        access("R7", 32'hE000_DFFC, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        access("R7", 32'hE000_E000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1, 4'b0000);
        access("R7", 32'hE000_EFFC, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1, 4'b0000);
        access("R7", 32'hE000_F000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000);
        access("R7", 32'hE002_E000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd2, 4'b0000);
        access("R7", 32'hE002_EFFC, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 2'd2, 4'b0000);
    endtask

    task automatic t_alias();
        access("R8", 32'hE002_E004, 1'b0, 1'b1, 1'b0, 4'b0100, 1'b0, 1'b0, 2'd0, 4'b0100);
        access("R8", 32'hE002_E004, 1'b0, 1'b1, 1'b1, 4'b0100, 1'b1, 1'b0, 2'd2, 4'b0000);
        access("R8", 32'hE002_E008, 1'b1, 1'b0, 1'b1, 4'b0001, 1'b1, 1'b1, 2'd2, 4'b0000);
        access("R8", 32'hE000_E004, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b0, 2'd0, 4'b0001);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'hE000_0100; req_priv = 1'b0; req_nonsec = 1'b0; sub_hit = '0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R9", "held valid", 32'(rsp_valid), 32'd1);
            check("R9", "held err", 32'(rsp_err), 32'd1);
            check("R9", "ready low", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        // back-to-back: new privileged request accepted as the held one retires
        rsp_ready = 1'b1;
        req_valid = 1'b1; req_addr = 32'hE000_E200; req_priv = 1'b1;
        #1;
        check("R9", "ready with rsp_ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "b2b valid", 32'(rsp_valid), 32'd1);
        check("R9", "b2b err", 32'(rsp_err), 32'd0);
        check("R9", "b2b region", 32'(rsp_region), 32'd1);
        @(negedge clk);
        check("R9", "b2b retired", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_priv_unpriv();
        t_regions();
        t_alias();
        t_hits();
        t_backpressure();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule